// File: doc/BRIEF.md
# Gate Drive Fault Supervisor

This block watches a set of already-digitized protection flags for a three-phase gate driver. It turns them into one fault output and a coast request that the gate logic uses to switch every power device off. Some flags are level conditions that release by themselves: an illegal rotor-position code, a low gate supply and over-temperature. Others are latched: repeated high-side gate droop, a bootstrap charge that does not finish in time, and a shorted motor lead.

For a high-side gate-source droop, the block first tries to recover. Each droop event raises a recharge request, so the high side is released and the low side is turned on to refill the bootstrap capacitor. Only the third such event within one commutation interval latches a fault. A charge timer runs while the sink-side device is on, and it latches a fault if the charge flag is still bad when the timer expires.

A commutation-edge strobe clears the droop and bootstrap faults. If the motor is stalled, no edges arrive, and only a reset clears them.

Top module: `gdfs_fault_supervisor`

## Requirements
- R1: A position code of 3'b000 or 3'b111 on `hall_code` drives `fault_out` high one cycle later. The six other codes leave it low, so this condition is not latched.
- R2: A droop event is a rising edge of `gs_droop` sampled while `hs_on` is high. It sets `recharge_req` one cycle later. A rising edge while `hs_on` is low has no effect. The request stays set until a cycle samples `sink_on` high and `boot_bad` low.
- R3: The third droop event since the last commutation edge latches a fault. The first and second events do not. The event count saturates at three.
- R4: A `comm_edge` pulse clears the droop count, the droop fault, the bootstrap fault and `recharge_req`. Without such a pulse, a latched droop fault persists.
- R5: The charge timer counts the cycles in which `sink_on` is high, up to CHG_CYCLES, and returns to zero whenever `sink_on` is low. A cycle with `sink_on` and `boot_bad` high and the timer at CHG_CYCLES latches a bootstrap fault. So the fault appears after CHG_CYCLES+1 consecutive sampled cycles, and not after fewer.
- R6: `lead_short` latches a fault only in a cycle where `hs_on` is high. `comm_edge` does not clear that fault; only reset does.
- R7: From reset, `coast_req` is held high until a cycle samples `supply_ok` high. It rises again one cycle after `supply_ok` falls.
- R8: `over_temp` high drives `fault_out` high one cycle later. The fault releases one cycle after `over_temp` falls.
- R9: Reset clears every latched fault and `recharge_req`.
- R10: `coast_req` always equals `fault_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_code | input | 3 | Rotor position code |
| gs_droop | input | 1 | High-side gate-source droop flag |
| boot_bad | input | 1 | Bootstrap charge current high or phase node high |
| supply_ok | input | 1 | Gate supply above its threshold |
| over_temp | input | 1 | Over-temperature flag |
| lead_short | input | 1 | Motor lead short flag |
| comm_edge | input | 1 | One-cycle commutation strobe |
| sink_on | input | 1 | A sink-side device is on |
| hs_on | input | 1 | A high-side device is on |
| coast_req | output | 1 | Request to switch all devices off |
| recharge_req | output | 1 | Release high side and recharge bootstrap |
| fault_out | output | 1 | Fault indication |

## Verification
Every internal register reaches the ports within one cycle, through `fault_out` or `recharge_req`. A wrong droop count shows up as a fault on the second or fourth event instead of the third. An off-by-one charge timer shows up as a fault one cycle early or one cycle late within a sweep around CHG_CYCLES. A clear that is missing or too broad shows up as a fault that survives, or vanishes at, the cycle after a commutation strobe.

// File: rtl/gdfs_pkg.sv
package gdfs_pkg;
    localparam int DROOP_LIMIT_DEF = 3;

    function automatic logic pos_code_illegal(input logic [2:0] code);
        return (code == 3'b000) || (code == 3'b111);
    endfunction
endpackage

// File: rtl/gdfs_droop_track.sv
module gdfs_droop_track #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gs_droop,
    input  logic hs_on,
    input  logic comm_edge,
    input  logic sink_on,
    input  logic boot_bad,
    output logic recharge,
    output logic droop_fault
);
    localparam int CW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
        logic          rchg;
        logic          flt;
    } st_t;

    st_t s_d, s_q;
    logic evt;

    always_comb begin
        s_d      = s_q;
        evt      = gs_droop && !s_q.prev && hs_on;
        s_d.prev = gs_droop;
        if (comm_edge) begin
            s_d.cnt  = '0;
            s_d.rchg = 1'b0;
            s_d.flt  = 1'b0;
        end else begin
            if (evt) begin
                if (s_q.cnt != CW'(LIMIT)) s_d.cnt = s_q.cnt + 1'b1;
                if (s_q.cnt >= CW'(LIMIT - 1)) s_d.flt = 1'b1;
                s_d.rchg = 1'b1;
            end else if (sink_on && !boot_bad) begin
                s_d.rchg = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign recharge    = s_q.rchg;
    assign droop_fault = s_q.flt;
endmodule

// File: rtl/gdfs_charge_timer.sv
module gdfs_charge_timer #(
    parameter int CYCLES = 34000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sink_on,
    input  logic boot_bad,
    input  logic comm_edge,
    output logic boot_fault
);
    localparam int TW = $clog2(CYCLES + 1);

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic          flt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!sink_on)                   s_d.tmr = '0;
        else if (s_q.tmr != TW'(CYCLES)) s_d.tmr = s_q.tmr + 1'b1;
        if (comm_edge)
            s_d.flt = 1'b0;
        else if (sink_on && boot_bad && s_q.tmr == TW'(CYCLES))
            s_d.flt = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign boot_fault = s_q.flt;
endmodule

// File: rtl/gdfs_level_flags.sv
module gdfs_level_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_code,
    input  logic       supply_ok,
    input  logic       over_temp,
    input  logic       lead_short,
    input  logic       hs_on,
    output logic       pos_bad,
    output logic       uv,
    output logic       ot,
    output logic       lead_flt
);
    import gdfs_pkg::*;

    typedef struct packed {
        logic pos;
        logic uv;
        logic ot;
        logic lead;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d.pos  = pos_code_illegal(hall_code);
        s_d.uv   = !supply_ok;
        s_d.ot   = over_temp;
        s_d.lead = s_q.lead || (lead_short && hs_on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{pos: 1'b0, uv: 1'b1, ot: 1'b0, lead: 1'b0};
        else        s_q <= s_d;
    end

    assign pos_bad  = s_q.pos;
    assign uv       = s_q.uv;
    assign ot       = s_q.ot;
    assign lead_flt = s_q.lead;
endmodule

// File: rtl/gdfs_fault_supervisor.sv
module gdfs_fault_supervisor #(
    parameter int DROOP_LIMIT = gdfs_pkg::DROOP_LIMIT_DEF,
    parameter int CHG_CYCLES  = 34000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_code,
    input  logic       gs_droop,
    input  logic       boot_bad,
    input  logic       supply_ok,
    input  logic       over_temp,
    input  logic       lead_short,
    input  logic       comm_edge,
    input  logic       sink_on,
    input  logic       hs_on,
    output logic       coast_req,
    output logic       recharge_req,
    output logic       fault_out
);
    logic droop_flt, boot_flt, pos_bad, uv, ot, lead_flt;

    gdfs_droop_track #(.LIMIT(DROOP_LIMIT)) u_droop (
        .clk(clk), .rst_n(rst_n), .gs_droop(gs_droop), .hs_on(hs_on),
        .comm_edge(comm_edge), .sink_on(sink_on), .boot_bad(boot_bad),
        .recharge(recharge_req), .droop_fault(droop_flt)
    );

    gdfs_charge_timer #(.CYCLES(CHG_CYCLES)) u_chg (
        .clk(clk), .rst_n(rst_n), .sink_on(sink_on), .boot_bad(boot_bad),
        .comm_edge(comm_edge), .boot_fault(boot_flt)
    );

    gdfs_level_flags u_lvl (
        .clk(clk), .rst_n(rst_n), .hall_code(hall_code), .supply_ok(supply_ok),
        .over_temp(over_temp), .lead_short(lead_short), .hs_on(hs_on),
        .pos_bad(pos_bad), .uv(uv), .ot(ot), .lead_flt(lead_flt)
    );

    always_comb begin
        fault_out = droop_flt | boot_flt | pos_bad | uv | ot | lead_flt;
        coast_req = fault_out;
    end
endmodule

// File: rtl/gdfs_sva.sv
module gdfs_sva (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_code,
    input logic       gs_droop,
    input logic       supply_ok,
    input logic       over_temp,
    input logic       lead_short,
    input logic       comm_edge,
    input logic       hs_on,
    input logic       coast_req,
    input logic       recharge_req,
    input logic       fault_out
);
    p_pos_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_code == 3'b000 || hall_code == 3'b111) |=> fault_out);

    p_recharge_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recharge_req) |-> $past(gs_droop && hs_on));

    p_comm_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        comm_edge |=> !recharge_req);

    p_lead_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_short && hs_on) |=> fault_out);

    p_lead_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lead_short && hs_on) |=> ##1 fault_out);

    p_uv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> coast_req);

    p_ot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        over_temp |=> fault_out);

    always_comb begin
        if (rst_n) begin
            p_coast_eq_r10: assert (coast_req == fault_out);
        end
    end
endmodule

bind gdfs_fault_supervisor gdfs_sva u_sva (
    .clk(clk), .rst_n(rst_n), .hall_code(hall_code), .gs_droop(gs_droop),
    .supply_ok(supply_ok), .over_temp(over_temp), .lead_short(lead_short),
    .comm_edge(comm_edge), .hs_on(hs_on), .coast_req(coast_req),
    .recharge_req(recharge_req), .fault_out(fault_out)
);

// File: tb/sim_gdfs_fault_supervisor.sv
module sim_gdfs_fault_supervisor;
    localparam int CYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] hall_code = 3'b101;
    logic gs_droop = 1'b0, boot_bad = 1'b0, supply_ok = 1'b0, over_temp = 1'b0;
    logic lead_short = 1'b0, comm_edge = 1'b0, sink_on = 1'b0, hs_on = 1'b0;
    logic coast_req, recharge_req, fault_out;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    gdfs_fault_supervisor #(.DROOP_LIMIT(3), .CHG_CYCLES(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .hall_code(hall_code), .gs_droop(gs_droop),
        .boot_bad(boot_bad), .supply_ok(supply_ok), .over_temp(over_temp),
        .lead_short(lead_short), .comm_edge(comm_edge), .sink_on(sink_on),
        .hs_on(hs_on), .coast_req(coast_req), .recharge_req(recharge_req),
        .fault_out(fault_out)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
        n_chk++;
        if (coast_req !== fault_out) begin
            n_err++;
            $display("FAIL R10: actual coast=%b expected=%b", coast_req, fault_out);
        end
    endtask

    task automatic comm_pulse();
        comm_edge = 1'b1; tick();
        comm_edge = 1'b0;
    endtask

    task automatic droop_pulse();
        gs_droop = 1'b1; tick();
        gs_droop = 1'b0; tick();
    endtask

    initial begin
        #200000;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        tick(2);
        chk("R7 reset coast", coast_req, 1'b1);
        chk("R9 reset recharge", recharge_req, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R7 coast until supply ok", coast_req, 1'b1);
        supply_ok = 1'b1; tick();
        chk("R7 supply good", fault_out, 1'b0);
        supply_ok = 1'b0; tick();
        chk("R7 supply lost", coast_req, 1'b1);
        supply_ok = 1'b1; tick();

        // R1 sweep of all position codes
        for (int h = 0; h < 8; h++) begin
            hall_code = 3'(h); tick();
            chk("R1 position code", fault_out, (h == 0 || h == 7));
        end
        hall_code = 3'b101; tick();
        chk("R1 release", fault_out, 1'b0);

        // R2 droop ignored with high side off
        hs_on = 1'b0; droop_pulse();
        chk("R2 droop ignored hs off", recharge_req, 1'b0);

        // R2/R3/R4 sweep of event counts
        for (int n = 1; n <= 5; n++) begin
            hs_on = 1'b1; comm_pulse();
            for (int k = 0; k < n; k++) droop_pulse();
            chk("R2 recharge set", recharge_req, 1'b1);
            chk("R3 droop fault count", fault_out, (n >= 3));
            if (n >= 3) begin
                tick(20);
                chk("R4 stalled fault persists", fault_out, 1'b1);
            end
            comm_pulse();
            chk("R4 comm clears fault", fault_out, 1'b0);
            chk("R4 comm clears recharge", recharge_req, 1'b0);
        end
        comm_pulse();
        droop_pulse();
        chk("R2 recharge held", recharge_req, 1'b1);
        sink_on = 1'b1; boot_bad = 1'b1; tick();
        chk("R2 recharge held while bad", recharge_req, 1'b1);
        boot_bad = 1'b0; tick();
        chk("R2 recharge done", recharge_req, 1'b0);
        sink_on = 1'b0; hs_on = 1'b0; tick();
        comm_pulse();

        // R5 charge timer sweep
        for (int n = CYC - 1; n <= CYC + 3; n++) begin
            sink_on = 1'b1; boot_bad = 1'b1;
            tick(n);
            chk("R5 charge timeout", fault_out, (n >= CYC + 1));
            sink_on = 1'b0; boot_bad = 1'b0; tick();
            comm_pulse();
            chk("R4 comm clears boot fault", fault_out, 1'b0);
        end
        sink_on = 1'b1; boot_bad = 1'b1; tick(CYC);
        sink_on = 1'b0; tick();
        sink_on = 1'b1; tick(CYC);
        chk("R5 timer restarts", fault_out, 1'b0);
        tick();
        chk("R5 timer after restart", fault_out, 1'b1);
        sink_on = 1'b0; boot_bad = 1'b0; tick();
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick();
        chk("R9 reset clears boot fault", fault_out, 1'b0);

        // R8 over-temperature
        over_temp = 1'b1; tick();
        chk("R8 over temp", fault_out, 1'b1);
        over_temp = 1'b0; tick();
        chk("R8 release", fault_out, 1'b0);

        // R6 lead short
        lead_short = 1'b1; hs_on = 1'b0; tick();
        chk("R6 ignored hs off", fault_out, 1'b0);
        hs_on = 1'b1; tick();
        chk("R6 lead fault", fault_out, 1'b1);
        lead_short = 1'b0; hs_on = 1'b0; comm_pulse();
        chk("R6 sticky over comm", fault_out, 1'b1);
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick();
        chk("R9 reset clears lead fault", fault_out, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule